// File: doc/BRIEF.md
# Converter Result Output Port

This block is the host-facing output stage of a 16-bit sampling converter. It captures each finished conversion word when the converter core pulses a done strobe. It applies the selected output coding as it captures the word. It then presents the word on a shared 16-pin bus in one of two ways. In parallel mode the whole word is driven at once. A swap input can exchange the two byte lanes, so an 8-bit host can read both halves through one lane. In serial mode the word leaves most significant bit first on pin 0, one bit per host serial clock pulse.

The active-low chip-select and read inputs are combined into a single enable, and the pins float whenever either input is high. Each pin carries a separate output-enable bit so that the pad ring can build tri-state drivers. A busy flag covers the time from the start of a conversion until its result is in the output register. The previous result stays readable for that whole time. A result that completes while a read is still in progress is parked and transferred once the read ends, so a word or byte pair that is partly read is never mixed with a newer result.

Top module: `adc_result_port`

## Requirements
- R1: After reset busy is 0, the output register holds 0, and with cs_n or rd_n high every bus_oe bit is 0.
- R2: Whenever cs_n or rd_n is high, bus_oe is all zeros and bus_out is all zeros, in both modes.
- R3: In parallel mode (ser_mode=0) with cs_n=rd_n=0 and byte_swap=0, bus_oe is all ones and bus_out[15:8] is the upper byte of the output register, while bus_out[7:0] is its lower byte.
- R4: In parallel mode with byte_swap=1, bus_out[15:8] carries the lower byte and bus_out[7:0] carries the upper byte. The change follows byte_swap with no clock delay.
- R5: A word is captured on the clock where conv_done=1. With fmt_twos=1 the stored value is conv_word with bit 15 inverted (two's complement). With fmt_twos=0 conv_word is stored unchanged (offset binary).
- R6: In serial mode (ser_mode=1) with cs_n=rd_n=0, bus_oe is 16'h0001 and bus_out[15:1] is 0. After k complete sclk pulses (k<16), bus_out[0] is bit 15-k of the output register. A pulse counts as complete on the first clock where sclk is seen low after it was seen high.
- R7: In serial mode, after 16 or more complete sclk pulses bus_out[0] is 0.
- R8: A clock where cs_n is high returns the serial position to the most significant bit.
- R9: busy rises on the clock after conv_start=1 and falls on the clock where the result enters the output register.
- R10: A conv_done that arrives during an active read does not change the output register. An active read is a parallel read with cs_n=rd_n=0, or a serial transfer after 1 to 15 pulses with cs_n low. The result loads one clock after the read ends, and busy stays high until then.
- R11: While busy is high, a read returns the previously captured result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion start pulse from the converter core |
| conv_done | input | 1 | Conversion finished strobe |
| conv_word | input | 16 | Finished result in offset binary |
| fmt_twos | input | 1 | 1 selects two's complement, 0 selects offset binary |
| ser_mode | input | 1 | 0 selects parallel, 1 selects serial |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| byte_swap | input | 1 | Exchanges the byte lanes in parallel mode |
| sclk | input | 1 | Host serial clock, sampled by clk |
| busy | output | 1 | Conversion in progress, result not yet latched |
| bus_out | output | 16 | Pin data |
| bus_oe | output | 16 | Per-pin output enable |

## Verification
The bench attacks a result that completes during a parallel read or mid-way through a serial transfer. A design that loaded at once would change the word under the host, and it would also drop busy too early. The bench drives more than sixteen serial clock pulses and toggles chip-select part-way through a transfer. A counter that wraps, or one that does not restart, shows up as wrong bits on pin 0. The bench also flips byte_swap between two reads and reads during a conversion, to catch a swapped lane order and a result exposed too soon.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    typedef enum logic {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } port_mode_e;

    function automatic logic [15:0] apply_coding(input logic [15:0] raw, input logic twos);
        apply_coding = raw ^ {twos, 15'b0};
    endfunction

endpackage

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             conv_done,
    input  logic [WIDTH-1:0] conv_word,
    input  logic             fmt_twos,
    input  logic             hold,
    output logic [WIDTH-1:0] word_q,
    output logic             busy
);
    localparam logic [WIDTH-1:0] SIGN_MASK = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] out;
        logic [WIDTH-1:0] pend;
        logic             pend_v;
        logic             busy;
    } latch_t;

    latch_t st_d, st_q;
    logic [WIDTH-1:0] coded;

    always_comb begin
        coded = fmt_twos ? (conv_word ^ SIGN_MASK) : conv_word;
        st_d  = st_q;
        if (conv_start) begin
            st_d.busy = 1'b1;
        end
        if (conv_done) begin
            if (hold) begin
                st_d.pend   = coded;
                st_d.pend_v = 1'b1;
            end else begin
                st_d.out    = coded;
                st_d.pend_v = 1'b0;
                st_d.busy   = 1'b0;
            end
        end else if (st_q.pend_v && !hold) begin
            st_d.out    = st_q.pend;
            st_d.pend_v = 1'b0;
            st_d.busy   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_q = st_q.out;
    assign busy   = st_q.busy;
endmodule

// File: rtl/adc_par_lanes.sv
module adc_par_lanes #(
    parameter int WIDTH  = 16,
    parameter int LANE_W = 8
) (
    input  logic [WIDTH-1:0] word,
    input  logic             swap,
    output logic [WIDTH-1:0] lanes
);
    localparam int LANES = WIDTH / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g*LANE_W +: LANE_W] = swap ? word[(LANES-1-g)*LANE_W +: LANE_W]
                                                : word[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/adc_ser_shift.sv
module adc_ser_shift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [WIDTH-1:0] word,
    output logic             sdo,
    output logic             mid_xfer
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam int IW = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk_prev;
    } ser_t;

    ser_t st_d, st_q;
    logic [IW-1:0] idx;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk;
        if (cs_n) begin
            st_d.cnt = '0;
        end else if (st_q.sclk_prev && !sclk && (st_q.cnt < LAST)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx      = IW'(WIDTH - 1) - st_q.cnt[IW-1:0];
    assign sdo      = (st_q.cnt < LAST) ? word[idx] : 1'b0;
    assign mid_xfer = !cs_n && (st_q.cnt != '0) && (st_q.cnt < LAST);
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
    import adc_port_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int LANE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             conv_done,
    input  logic [WIDTH-1:0] conv_word,
    input  logic             fmt_twos,
    input  logic             ser_mode,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             byte_swap,
    input  logic             sclk,
    output logic             busy,
    output logic [WIDTH-1:0] bus_out,
    output logic [WIDTH-1:0] bus_oe
);
    port_mode_e       mode;
    logic             out_off;
    logic             hold;
    logic             sdo;
    logic             mid_xfer;
    logic [WIDTH-1:0] word_q;
    logic [WIDTH-1:0] lanes;

    assign mode    = port_mode_e'(ser_mode);
    assign out_off = cs_n | rd_n;
    assign hold    = (mode == MODE_SER) ? mid_xfer : !out_off;

    adc_result_latch #(.WIDTH(WIDTH)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .conv_word  (conv_word),
        .fmt_twos   (fmt_twos),
        .hold       (hold),
        .word_q     (word_q),
        .busy       (busy)
    );

    adc_par_lanes #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_lanes (
        .word  (word_q),
        .swap  (byte_swap),
        .lanes (lanes)
    );

    adc_ser_shift #(.WIDTH(WIDTH)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .word     (word_q),
        .sdo      (sdo),
        .mid_xfer (mid_xfer)
    );

    always_comb begin
        bus_out = '0;
        bus_oe  = '0;
        if (!out_off) begin
            if (mode == MODE_SER) begin
                bus_out[0] = sdo;
                bus_oe[0]  = 1'b1;
            end else begin
                bus_out = lanes;
                bus_oe  = '1;
            end
        end
    end
endmodule

// File: rtl/adc_result_port_chk.sv
module adc_result_port_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_start,
    input logic             conv_done,
    input logic             ser_mode,
    input logic             cs_n,
    input logic             rd_n,
    input logic             byte_swap,
    input logic             busy,
    input logic [WIDTH-1:0] bus_out,
    input logic [WIDTH-1:0] bus_oe
);
    logic par_rd;
    assign par_rd = !ser_mode && !cs_n && !rd_n;

    a_r2_float_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (bus_oe == '0 && bus_out == '0));

    a_r6_serial_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && !cs_n && !rd_n) |-> ($countones(bus_oe) == 1 && bus_oe[0] && bus_out[WIDTH-1:1] == '0));

    a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !conv_done) |=> busy);

    a_r10_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (par_rd && $past(par_rd) && $stable(byte_swap)) |-> $stable(bus_out));

    a_r3_full_bus: assert property (@(posedge clk) disable iff (!rst_n)
        par_rd |-> (bus_oe == '1));
endmodule

bind adc_result_port adc_result_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .ser_mode   (ser_mode),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .byte_swap  (byte_swap),
    .busy       (busy),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe)
);

// File: tb/adc_result_port_bench.sv
module adc_result_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start = 1'b0, conv_done = 1'b0;
    logic [15:0] conv_word = '0;
    logic        fmt_twos = 1'b0, ser_mode = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, byte_swap = 1'b0, sclk = 1'b0;
    logic        busy;
    logic [15:0] bus_out, bus_oe;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference state
    logic [15:0] m_out = '0;
    logic [15:0] m_pq[$];
    bit          m_busy = 1'b0;
    int          m_cnt = 0;
    bit          m_prev = 1'b0;

    always #10 clk = ~clk;

    adc_result_port u_adc_result_port (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
        .conv_word(conv_word), .fmt_twos(fmt_twos), .ser_mode(ser_mode), .cs_n(cs_n),
        .rd_n(rd_n), .byte_swap(byte_swap), .sclk(sclk), .busy(busy),
        .bus_out(bus_out), .bus_oe(bus_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, advanced on each active edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = '0; m_pq.delete(); m_busy = 0; m_cnt = 0; m_prev = 0;
        end else begin
            bit reading;
            logic [15:0] w;
            if (ser_mode) reading = !cs_n && m_cnt >= 1 && m_cnt <= 15;
            else          reading = !cs_n && !rd_n;
            w = fmt_twos ? {~conv_word[15], conv_word[14:0]} : conv_word;
            if (conv_start) m_busy = 1;
            if (conv_done) begin
                if (reading) begin m_pq.delete(); m_pq.push_back(w); end
                else begin m_out = w; m_pq.delete(); m_busy = 0; end
            end else if (m_pq.size() != 0 && !reading) begin
                m_out = m_pq.pop_front(); m_busy = 0;
            end
            if (cs_n) m_cnt = 0;
            else if (m_prev && !sclk && m_cnt < 16) m_cnt++;
            m_prev = sclk;
        end
    end

    // compare every cycle, late in the low phase
    always @(negedge clk) begin
        #8;
        if (rst_n && !done) begin
            logic [15:0] eo, ed;
            string tag;
            eo = '0; ed = '0;
            if (cs_n || rd_n) tag = "R2";
            else if (ser_mode) begin
                eo = 16'h0001;
                ed[0] = (m_cnt < 16) ? m_out[15 - m_cnt] : 1'b0;
                tag = (m_cnt < 16) ? "R6" : "R7";
            end else begin
                eo = '1;
                ed = byte_swap ? {m_out[7:0], m_out[15:8]} : m_out;
                tag = byte_swap ? "R4" : "R3";
            end
            check({tag, " oe"}, bus_oe, eo);
            check({tag, " data"}, bus_out, ed);
            check("R9 busy", {15'b0, busy}, {15'b0, m_busy});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sample;
        @(negedge clk); #9;
    endtask

    task automatic start_conv;
        @(negedge clk); conv_start = 1;
        @(negedge clk); conv_start = 0;
        cyc(2);
    endtask

    task automatic finish_conv(input logic [15:0] w, input logic twos);
        @(negedge clk); conv_done = 1; conv_word = w; fmt_twos = twos;
        @(negedge clk); conv_done = 0;
    endtask

    task automatic pulse(input int n);
        repeat (n) begin
            @(negedge clk); sclk = 1; cyc(1);
            @(negedge clk); sclk = 0; cyc(1);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        #9;
        check("R1 busy", {15'b0, busy}, 16'h0000);
        check("R1 oe", bus_oe, 16'h0000);
        @(negedge clk); rst_n = 1;
        @(negedge clk); cs_n = 0; rd_n = 0;
        sample;
        check("R1 reset word", bus_out, 16'h0000);

        // parallel, both lane orders (R3, R4)
        @(negedge clk); rd_n = 1;
        start_conv; finish_conv(16'h12A5, 0);
        @(negedge clk); rd_n = 0;
        sample; check("R3 straight lanes", bus_out, 16'h12A5);
        @(negedge clk); byte_swap = 1;
        sample; check("R4 swapped lanes", bus_out, 16'hA512);
        @(negedge clk); byte_swap = 0;

        // coding (R5)
        @(negedge clk); rd_n = 1;
        start_conv; finish_conv(16'h8001, 1);
        @(negedge clk); rd_n = 0;
        sample; check("R5 twos", bus_out, 16'h0001);
        @(negedge clk); rd_n = 1;
        start_conv; finish_conv(16'h7FFE, 0);
        @(negedge clk); rd_n = 0;
        sample; check("R5 offset", bus_out, 16'h7FFE);

        // read during conversion (R11)
        @(negedge clk); rd_n = 1;
        start_conv;
        @(negedge clk); rd_n = 0;
        sample; check("R11 previous during busy", bus_out, 16'h7FFE);
        check("R11 busy high", {15'b0, busy}, 16'h0001);
        @(negedge clk); rd_n = 1;
        finish_conv(16'h3C3C, 0);

        // result arriving during a read (R10), across a byte pair
        @(negedge clk); rd_n = 0;
        start_conv;
        finish_conv(16'hBEEF, 0);
        cyc(2);
        sample; check("R10 held word", bus_out, 16'h3C3C);
        check("R10 busy stays", {15'b0, busy}, 16'h0001);
        @(negedge clk); byte_swap = 1;
        sample; check("R10 held swapped", bus_out, 16'h3C3C);
        @(negedge clk); byte_swap = 0; rd_n = 1;
        cyc(2);
        @(negedge clk); rd_n = 0;
        sample; check("R10 loaded after read", bus_out, 16'hBEEF);

        // serial (R6, R7, R8)
        @(negedge clk); cs_n = 1; rd_n = 1; ser_mode = 1;
        start_conv; finish_conv(16'hC3A5, 0);
        @(negedge clk); cs_n = 0; rd_n = 0;
        sample; check("R6 first bit", bus_out, 16'h0001);
        pulse(16);
        sample; check("R7 after 16", bus_out, 16'h0000);
        pulse(3);
        sample; check("R7 extra pulses", bus_out, 16'h0000);
        @(negedge clk); cs_n = 1;
        @(negedge clk); cs_n = 0;
        sample; check("R8 restart msb", bus_out, 16'h0001);
        pulse(5);
        // bit 10 of C3A5 is 0
        sample; check("R6 after 5", bus_out, 16'h0000);
        start_conv; finish_conv(16'h0F0F, 0);
        sample; check("R10 serial held", bus_out, 16'h0000);
        @(negedge clk); cs_n = 1;
        cyc(2);
        @(negedge clk); cs_n = 0;
        sample; check("R8 new word msb", bus_out, 16'h0000);
        pulse(4);
        sample; check("R6 new word bit11", bus_out, 16'h0001);
        pulse(14);
        @(negedge clk); rd_n = 1;
        sample; check("R2 serial off", bus_oe, 16'h0000);
        cyc(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule